// File: doc/BRIEF.md
# Timekeeping Counter Core with Line-Qualified Interval Timing

This block keeps three binary counters that all advance from one 256 Hz tick. A 40-bit real-time counter runs freely. Its low byte holds fractions of a second and its upper four bytes hold whole seconds. A 40-bit interval timer is gated by one of two sources. In automatic mode the gate is a debounced view of a monitored data line. In manual mode it is a stop control bit. A 32-bit cycle counter counts falling edges of the same line, but only edges that pass the debounce.

The debounce uses a qualifier. The qualifier's level follows the synchronized line only after the line has held its new value for a whole number of ticks. A select input chooses between a short delay and a long delay. The interval timer in automatic mode runs while the qualified level is high. The cycle counter advances once each time the qualified level goes from high to low.

An oscillator enable input freezes everything that depends on the tick when it is low. Each counter has a synchronous parallel load for register writes.

Top module: `tk_counters`

## Requirements
- R1: After reset all three counters read zero and the qualified line level is low.
- R2: While `osc_en_i` is 1, each cycle with `tick_i` high adds one to the real-time counter. Cycles without a tick leave it unchanged.
- R3: While `osc_en_i` is 0, no counter advances and the qualifier does not move, whatever `tick_i` and `line_i` do.
- R4: Each counter wraps from all ones to zero on an increment.
- R5: A load strobe writes its value on the next clock edge. The load wins over an increment in the same cycle, and it works whether or not the oscillator is enabled.
- R6: With `auto_mode_i` at 0, the interval timer adds one per enabled tick while `halt_i` is 0 and holds while `halt_i` is 1.
- R7: With `auto_mode_i` at 1, `halt_i` has no effect. The qualified level rises on the D-th consecutive enabled tick that sees the line high. The interval timer counts from the next tick onward.
- R8: In automatic mode the qualified level falls on the D-th consecutive enabled tick that sees the line low. That tick still adds one to the interval timer, and later ticks do not.
- R9: D is `DLY_SHORT` (default 3) when `dly_sel_i` is 0 and `DLY_LONG` (default 6) when `dly_sel_i` is 1.
- R10: The cycle counter adds one on the tick where the qualified level falls. Short low pulses that never qualify are not counted.
- R11: If the line returns to the qualified level before D ticks have passed, the tick count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse at 256 Hz |
| line_i | input | 1 | Synchronized data-line level |
| osc_en_i | input | 1 | Oscillator enable; 0 freezes all timekeeping |
| auto_mode_i | input | 1 | 1 selects automatic interval gating, 0 selects manual |
| halt_i | input | 1 | Manual-mode stop: 1 halts the interval timer |
| dly_sel_i | input | 1 | Qualification delay select (0 short, 1 long) |
| rtc_ld_i | input | 1 | Real-time counter load strobe |
| rtc_ld_val_i | input | 40 | Real-time counter load value |
| ivl_ld_i | input | 1 | Interval timer load strobe |
| ivl_ld_val_i | input | 40 | Interval timer load value |
| cyc_ld_i | input | 1 | Cycle counter load strobe |
| cyc_ld_val_i | input | 32 | Cycle counter load value |
| rtc_o | output | 40 | Real-time counter value |
| ivl_o | output | 40 | Interval timer value |
| cyc_o | output | 32 | Cycle counter value |

## Verification
The in-line properties check these rules on every cycle:
- a load always wins;
- a counter steps by exactly one, or stays still, according to its increment enable;
- the qualifier moves only on an enabled tick;
- with the oscillator off, the real-time counter is frozen;
- in manual mode with the halt bit set, the interval timer is frozen;
- the cycle counter moves only on a qualified fall.

Some behaviour only the bench scenarios can show, because it depends on tick counts held across many cycles:
- the exact tick on which automatic mode starts or stops the interval timer under each delay select;
- that a short pulse restarts the qualification count;
- that glitches never reach the cycle counter.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int unsigned TK_RTC_W  = 40;
  localparam int unsigned TK_IVL_W  = 40;
  localparam int unsigned TK_CYC_W  = 32;
  localparam int unsigned TK_DLY_S  = 3;
  localparam int unsigned TK_DLY_L  = 6;

  typedef enum logic {
    IVL_MANUAL = 1'b0,
    IVL_AUTO   = 1'b1
  } ivl_mode_e;
endpackage

// File: rtl/tk_line_qual.sv
module tk_line_qual #(
  parameter int unsigned DLY_SHORT = 3,
  parameter int unsigned DLY_LONG  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en_i,
  input  logic line_i,
  input  logic sel_i,
  output logic level_o,
  output logic fall_o
);
  localparam int unsigned DMAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
  localparam int unsigned CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, dly;
  logic          lvl_q, lvl_d, expire;

  always_comb begin
    dly    = sel_i ? CW'(DLY_LONG) : CW'(DLY_SHORT);
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (line_i == lvl_q) begin
      cnt_d = '0;
    end else if (tick_en_i) begin
      if (cnt_q >= dly - CW'(1)) begin
        expire = 1'b1;
        lvl_d  = line_i;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign level_o = lvl_q;
  assign fall_o  = expire & lvl_q;

  assert_qual_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en_i |=> $stable(level_o));
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (ld_i)       cnt_d = ld_val_i;
    else if (inc_i) cnt_d = cnt_q + W'(1);
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> cnt_o == $past(ld_val_i));
  assert_step_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i) |=> cnt_o == $past(cnt_o) + W'(1));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !ld_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tk_counters.sv
module tk_counters
  import tk_pkg::*;
#(
  parameter int unsigned RTC_W     = TK_RTC_W,
  parameter int unsigned IVL_W     = TK_IVL_W,
  parameter int unsigned CYC_W     = TK_CYC_W,
  parameter int unsigned DLY_SHORT = TK_DLY_S,
  parameter int unsigned DLY_LONG  = TK_DLY_L
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic             osc_en_i,
  input  logic             auto_mode_i,
  input  logic             halt_i,
  input  logic             dly_sel_i,
  input  logic             rtc_ld_i,
  input  logic [RTC_W-1:0] rtc_ld_val_i,
  input  logic             ivl_ld_i,
  input  logic [IVL_W-1:0] ivl_ld_val_i,
  input  logic             cyc_ld_i,
  input  logic [CYC_W-1:0] cyc_ld_val_i,
  output logic [RTC_W-1:0] rtc_o,
  output logic [IVL_W-1:0] ivl_o,
  output logic [CYC_W-1:0] cyc_o
);
  logic      tick_en, q_level, q_fall, ivl_run;
  ivl_mode_e mode;

  assign tick_en = tick_i & osc_en_i;
  assign mode    = ivl_mode_e'(auto_mode_i);

  always_comb begin
    unique case (mode)
      IVL_AUTO:   ivl_run = q_level;
      default:    ivl_run = ~halt_i;
    endcase
  end

  tk_line_qual #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .line_i(line_i),
    .sel_i(dly_sel_i), .level_o(q_level), .fall_o(q_fall)
  );

  tk_counter #(.W(RTC_W)) u_rtc (
    .clk(clk), .rst_n(rst_n), .ld_i(rtc_ld_i), .ld_val_i(rtc_ld_val_i),
    .inc_i(tick_en), .cnt_o(rtc_o)
  );

  tk_counter #(.W(IVL_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .ld_i(ivl_ld_i), .ld_val_i(ivl_ld_val_i),
    .inc_i(tick_en & ivl_run), .cnt_o(ivl_o)
  );

  tk_counter #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .ld_i(cyc_ld_i), .ld_val_i(cyc_ld_val_i),
    .inc_i(q_fall), .cnt_o(cyc_o)
  );

  assert_osc_off_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en_i && !rtc_ld_i) |=> $stable(rtc_o));
  assert_manual_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode_i && halt_i && !ivl_ld_i) |=> $stable(ivl_o));
  assert_cyc_only_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_ld_i && !q_fall) |=> $stable(cyc_o));
endmodule

// File: tb/tk_counters_test.sv
module tk_counters_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, line_i, osc_en_i, auto_mode_i, halt_i, dly_sel_i;
  logic        rtc_ld_i, ivl_ld_i, cyc_ld_i;
  logic [39:0] rtc_ld_val_i, ivl_ld_val_i;
  logic [31:0] cyc_ld_val_i;
  logic [39:0] rtc_o, ivl_o;
  logic [31:0] cyc_o;
  int tests  = 0;
  int failed = 0;

  always #5 clk = ~clk;

  tk_counters uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .line_i(line_i),
    .osc_en_i(osc_en_i), .auto_mode_i(auto_mode_i), .halt_i(halt_i),
    .dly_sel_i(dly_sel_i), .rtc_ld_i(rtc_ld_i), .rtc_ld_val_i(rtc_ld_val_i),
    .ivl_ld_i(ivl_ld_i), .ivl_ld_val_i(ivl_ld_val_i), .cyc_ld_i(cyc_ld_i),
    .cyc_ld_val_i(cyc_ld_val_i), .rtc_o(rtc_o), .ivl_o(ivl_o), .cyc_o(cyc_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic ld_all(input logic [39:0] r, input logic [39:0] v, input logic [31:0] c);
    @(negedge clk);
    rtc_ld_i = 1'b1; rtc_ld_val_i = r;
    ivl_ld_i = 1'b1; ivl_ld_val_i = v;
    cyc_ld_i = 1'b1; cyc_ld_val_i = c;
    @(negedge clk);
    rtc_ld_i = 1'b0; ivl_ld_i = 1'b0; cyc_ld_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "rtc", 64'(rtc_o), 64'd0);
    chk("R1", "ivl", 64'(ivl_o), 64'd0);
    chk("R1", "cyc", 64'(cyc_o), 64'd0);
  endtask

  task automatic t_rtc_count;
    osc_en_i = 1'b1; auto_mode_i = 1'b0; halt_i = 1'b1;
    ld_all(40'd100, 40'd0, 32'd0);
    tk(5);
    chk("R2", "rtc after 5 ticks", 64'(rtc_o), 64'd105);
    repeat (4) @(negedge clk);
    chk("R2", "rtc idle", 64'(rtc_o), 64'd105);
    chk("R6", "ivl halted", 64'(ivl_o), 64'd0);
  endtask

  task automatic t_osc_off;
    osc_en_i = 1'b0; halt_i = 1'b0; auto_mode_i = 1'b0;
    line_i = 1'b1; tk(8); line_i = 1'b0; tk(8);
    chk("R3", "rtc frozen", 64'(rtc_o), 64'd105);
    chk("R3", "ivl frozen", 64'(ivl_o), 64'd0);
    chk("R3", "cyc frozen", 64'(cyc_o), 64'd0);
    ld_all(40'h55, 40'h66, 32'h77);
    chk("R5", "rtc load osc off", 64'(rtc_o), 64'h55);
    chk("R5", "cyc load osc off", 64'(cyc_o), 64'h77);
  endtask

  task automatic t_load_priority;
    osc_en_i = 1'b1; auto_mode_i = 1'b0; halt_i = 1'b0;
    @(negedge clk);
    tick_i = 1'b1; rtc_ld_i = 1'b1; rtc_ld_val_i = 40'd7;
    ivl_ld_i = 1'b1; ivl_ld_val_i = 40'd9;
    @(negedge clk);
    tick_i = 1'b0; rtc_ld_i = 1'b0; ivl_ld_i = 1'b0;
    chk("R5", "rtc load beats tick", 64'(rtc_o), 64'd7);
    chk("R5", "ivl load beats tick", 64'(ivl_o), 64'd9);
  endtask

  task automatic t_wrap;
    osc_en_i = 1'b1; auto_mode_i = 1'b0; halt_i = 1'b0;
    ld_all({40{1'b1}}, {40{1'b1}}, 32'd0);
    tk(1);
    chk("R4", "rtc wrap", 64'(rtc_o), 64'd0);
    chk("R4", "ivl wrap", 64'(ivl_o), 64'd0);
  endtask

  task automatic t_manual;
    auto_mode_i = 1'b0; halt_i = 1'b0;
    ld_all(40'd0, 40'd0, 32'd0);
    tk(3);
    chk("R6", "ivl running", 64'(ivl_o), 64'd3);
    halt_i = 1'b1;
    tk(3);
    chk("R6", "ivl halted", 64'(ivl_o), 64'd3);
  endtask

  task automatic t_auto;
    auto_mode_i = 1'b1; halt_i = 1'b1; dly_sel_i = 1'b0;
    ld_all(40'd0, 40'd0, 32'd0);
    line_i = 1'b1;
    tk(2);
    chk("R7", "ivl before qualify", 64'(ivl_o), 64'd0);
    tk(1);
    chk("R7", "ivl on qualify tick", 64'(ivl_o), 64'd0);
    tk(2);
    chk("R7", "ivl counts despite halt", 64'(ivl_o), 64'd2);
    line_i = 1'b0;
    tk(2);
    chk("R8", "ivl still counting", 64'(ivl_o), 64'd4);
    chk("R10", "cyc before fall qualifies", 64'(cyc_o), 64'd0);
    tk(1);
    chk("R8", "ivl on stop tick", 64'(ivl_o), 64'd5);
    chk("R10", "cyc after qualified fall", 64'(cyc_o), 64'd1);
    tk(2);
    chk("R8", "ivl stopped", 64'(ivl_o), 64'd5);
  endtask

  task automatic t_short_pulse;
    auto_mode_i = 1'b1; dly_sel_i = 1'b0;
    ld_all(40'd0, 40'd0, 32'd1);
    line_i = 1'b1; tk(2);
    line_i = 1'b0; tk(1);
    line_i = 1'b1; tk(2);
    chk("R11", "restart after glitch", 64'(ivl_o), 64'd0);
    tk(1);
    tk(1);
    chk("R11", "ivl after full qualify", 64'(ivl_o), 64'd1);
    line_i = 1'b0; tk(2);
    line_i = 1'b1; tk(1);
    chk("R10", "short low not counted", 64'(cyc_o), 64'd1);
    chk("R11", "ivl kept running", 64'(ivl_o), 64'd4);
    line_i = 1'b0; tk(3);
    chk("R10", "cyc counts real fall", 64'(cyc_o), 64'd2);
    chk("R8", "ivl stop value", 64'(ivl_o), 64'd7);
  endtask

  task automatic t_long_delay;
    auto_mode_i = 1'b1; dly_sel_i = 1'b1;
    ld_all(40'd0, 40'd0, 32'd2);
    line_i = 1'b1; tk(5);
    chk("R9", "long delay not yet", 64'(ivl_o), 64'd0);
    tk(1);
    tk(1);
    chk("R9", "long delay qualified", 64'(ivl_o), 64'd1);
    line_i = 1'b0; tk(5);
    chk("R9", "cyc before long low", 64'(cyc_o), 64'd2);
    tk(1);
    chk("R9", "cyc after long low", 64'(cyc_o), 64'd3);
    chk("R9", "ivl stop long", 64'(ivl_o), 64'd7);
    dly_sel_i = 1'b0;
  endtask

  task automatic t_cyc_wrap;
    auto_mode_i = 1'b1; dly_sel_i = 1'b0;
    ld_all(40'd0, 40'd0, 32'hFFFF_FFFF);
    line_i = 1'b1; tk(3);
    line_i = 1'b0; tk(3);
    chk("R4", "cyc wrap", 64'(cyc_o), 64'd0);
  endtask

  initial begin
    #2_000_000;
    tests++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; line_i = 1'b0; osc_en_i = 1'b0;
    auto_mode_i = 1'b0; halt_i = 1'b1; dly_sel_i = 1'b0;
    rtc_ld_i = 1'b0; ivl_ld_i = 1'b0; cyc_ld_i = 1'b0;
    rtc_ld_val_i = '0; ivl_ld_val_i = '0; cyc_ld_val_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rtc_count();
    t_osc_off();
    t_load_priority();
    t_wrap();
    t_manual();
    t_auto();
    t_short_pulse();
    t_long_delay();
    t_cyc_wrap();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule